// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds two predictors of branch direction and a third table that picks one of them for each branch. The per-branch predictor keeps one 2-bit saturating counter for each table slot, addressed by the low bits of the branch address. The history-based predictor keeps a shift register of the most recent resolved outcomes. Those history bits, joined to the low address bits, pick one of several 2-bit counters that belong to the branch, so the same branch can learn a different direction for each recent outcome pattern.

A chooser table of 2-bit counters, also addressed by the low address bits, decides which of the two predictions is output. The chooser moves only when the two components disagree on a resolved branch, and it moves toward the component that was right. It resets to a saturated value, so two such mispredictions are needed before the choice flips. A static configuration input, sampled while reset is held, sets the starting preference.

The fetch side presents an address and gets a combinational prediction in the same cycle. The resolve side presents an address and the real outcome. That input trains both components, the chooser and the history at the next clock edge.

Top module: `tourney_bp`

## Requirements
- R1: After reset every direction counter holds 1 (weakly not taken), the history is all zeros, and every lookup predicts not taken.
- R2: Direction counters saturate at 0 and 3, count up on a taken outcome and down on a not-taken outcome, and predict taken when their value is 2 or 3.
- R3: The per-branch counter and the chooser counter are both addressed by address bits [IDX_W-1:0], so addresses equal in those bits share entries.
- R4: The history-based counter is addressed by {address[IDX_W-1:0], history}. The history register shifts each resolved outcome into bit 0, with the newest outcome in bit 0.
- R5: A chooser value of 2 or 3 selects the history-based prediction and 0 or 1 selects the per-branch prediction. With cfg_prefer_global_i high during reset every chooser counter starts at 3, and with it low they start at 0.
- R6: On a resolved branch where the two component predictions disagree, the chooser counter steps one toward the component that matched the outcome, saturating at 0 and 3. When the two agree it does not change.
- R7: Both component counters for the resolved branch are trained on every resolve, whichever component was selected.
- R8: A lookup in the same cycle as a resolve sees the state from before that resolve. The effect of the resolve is visible to lookups from the next cycle.
- R9: While up_valid_i is low, no counter and no history bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_prefer_global_i | input | 1 | Starting chooser preference, sampled during reset (1 = history-based) |
| lk_pc_i | input | PC_W | Address of the branch being fetched |
| lk_taken_o | output | 1 | Predicted direction for lk_pc_i (1 = taken) |
| up_valid_i | input | 1 | A resolved branch is presented this cycle |
| up_pc_i | input | PC_W | Address of the resolved branch |
| up_taken_i | input | 1 | Real outcome of the resolved branch |

## Verification
A lookup and a resolve can fall in the same cycle, and they can address the same counters. The bench drives the two ports together on every cycle. The addresses are often equal or equal modulo the table depth, and sometimes the two match exactly. Each prediction is judged against a reference model whose state is advanced only after the comparison, so the design must return the pre-update value in that cycle and the trained value in the next one.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_MAX     = 2'd3;
  localparam ctr_t CTR_MIN     = 2'd0;
  localparam ctr_t CTR_WEAK_NT = 2'd1;

  function automatic ctr_t ctr_step(ctr_t c, logic inc);
    if (inc) return (c == CTR_MAX) ? c : c + 2'd1;
    else     return (c == CTR_MIN) ? c : c - 2'd1;
  endfunction

  function automatic logic ctr_hi(ctr_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table
  import tbp_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ctr_t             init_i,
  input  logic [IDX_W-1:0] lk_idx_i,
  output ctr_t             lk_ctr_o,
  input  logic [IDX_W-1:0] up_idx_i,
  output ctr_t             up_ctr_o,
  input  logic             up_en_i,
  input  logic             up_inc_i
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0][1:0] tbl_q;

  assign lk_ctr_o = tbl_q[lk_idx_i];
  assign up_ctr_o = tbl_q[up_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tbl_q <= {DEPTH{init_i}};
    else if (up_en_i) tbl_q[up_idx_i] <= ctr_step(up_ctr_o, up_inc_i);
  end

  assert_sat_top_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_en_i && up_inc_i && up_ctr_o == CTR_MAX |=> tbl_q[$past(up_idx_i)] == CTR_MAX);
  assert_sat_bot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_en_i && !up_inc_i && up_ctr_o == CTR_MIN |=> tbl_q[$past(up_idx_i)] == CTR_MIN);
  assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !up_en_i |=> $stable(tbl_q));
endmodule

// File: rtl/tbp_ghist.sv
module tbp_ghist #(
  parameter int HIST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              up_valid_i,
  input  logic              up_taken_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;
  assign hist_o = hist_q;

  generate
    if (HIST_W == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= '0;
        else if (up_valid_i) hist_q <= up_taken_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= '0;
        else if (up_valid_i) hist_q <= {hist_q[HIST_W-2:0], up_taken_i};
      end
      assert_hist_age_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        up_valid_i |=> hist_q[1] == $past(hist_q[0]));
    end
  endgenerate

  assert_hist_new_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_valid_i |=> hist_q[0] == $past(up_taken_i));
  assert_hist_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !up_valid_i |=> $stable(hist_q));
endmodule

// File: rtl/tourney_bp.sv
module tourney_bp
  import tbp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 4,
  parameter int HIST_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_prefer_global_i,
  input  logic [PC_W-1:0] lk_pc_i,
  output logic            lk_taken_o,
  input  logic            up_valid_i,
  input  logic [PC_W-1:0] up_pc_i,
  input  logic            up_taken_i
);
  localparam int GIDX_W = IDX_W + HIST_W;

  logic [HIST_W-1:0] hist;
  logic [IDX_W-1:0]  lk_idx, up_idx;
  ctr_t loc_lk, loc_up, glb_lk, glb_up, cho_lk, cho_up;
  logic loc_lk_p, glb_lk_p, loc_up_p, glb_up_p;
  logic disagree;
  ctr_t cho_init;

  logic unused_bits;
  assign unused_bits = ^{lk_pc_i[PC_W-1:IDX_W], up_pc_i[PC_W-1:IDX_W], cho_up};

  assign lk_idx   = lk_pc_i[IDX_W-1:0];
  assign up_idx   = up_pc_i[IDX_W-1:0];
  assign cho_init = cfg_prefer_global_i ? CTR_MAX : CTR_MIN;

  tbp_ghist #(.HIST_W(HIST_W)) i_hist (
    .clk_i, .rst_ni, .up_valid_i, .up_taken_i, .hist_o(hist)
  );

  tbp_ctr_table #(.IDX_W(IDX_W)) i_local (
    .clk_i, .rst_ni, .init_i(CTR_WEAK_NT),
    .lk_idx_i(lk_idx), .lk_ctr_o(loc_lk),
    .up_idx_i(up_idx), .up_ctr_o(loc_up),
    .up_en_i(up_valid_i), .up_inc_i(up_taken_i)
  );

  tbp_ctr_table #(.IDX_W(GIDX_W)) i_global (
    .clk_i, .rst_ni, .init_i(CTR_WEAK_NT),
    .lk_idx_i({lk_idx, hist}), .lk_ctr_o(glb_lk),
    .up_idx_i({up_idx, hist}), .up_ctr_o(glb_up),
    .up_en_i(up_valid_i), .up_inc_i(up_taken_i)
  );

  assign loc_lk_p = ctr_hi(loc_lk);
  assign glb_lk_p = ctr_hi(glb_lk);
  assign loc_up_p = ctr_hi(loc_up);
  assign glb_up_p = ctr_hi(glb_up);
  assign disagree = loc_up_p != glb_up_p;

  // chooser steps toward the history side when it was the correct one
  tbp_ctr_table #(.IDX_W(IDX_W)) i_chooser (
    .clk_i, .rst_ni, .init_i(cho_init),
    .lk_idx_i(lk_idx), .lk_ctr_o(cho_lk),
    .up_idx_i(up_idx), .up_ctr_o(cho_up),
    .up_en_i(up_valid_i && disagree), .up_inc_i(glb_up_p == up_taken_i)
  );

  assign lk_taken_o = ctr_hi(cho_lk) ? glb_lk_p : loc_lk_p;

  always_comb begin
    if (rst_ni && loc_lk_p == glb_lk_p)
      assert_agree_R5: assert (lk_taken_o == loc_lk_p);
  end
endmodule

// File: tb/test_tourney_bp.sv
`timescale 1ns/1ps
module test_tourney_bp;
  localparam int PC_W = 32, IDX_W = 4, HIST_W = 2;
  localparam int NL = 1 << IDX_W, NH = 1 << HIST_W;

  logic clk = 0, rst_ni = 0, cfg = 0;
  logic [PC_W-1:0] lk_pc = 0, up_pc = 0;
  logic up_valid = 0, up_taken = 0, lk_taken;
  int checks = 0, errors = 0;
  bit done = 0;

  int loc_m[NL], cho_m[NL], glb_m[NL*NH];
  int hist_m;

  always #10 clk = ~clk;

  tourney_bp #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) i_tourney_bp (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_prefer_global_i(cfg),
    .lk_pc_i(lk_pc), .lk_taken_o(lk_taken),
    .up_valid_i(up_valid), .up_pc_i(up_pc), .up_taken_i(up_taken)
  );

  function automatic bit m_pred(int pc);
    int i = pc % NL;
    bit l = loc_m[i] >= 2;
    bit g = glb_m[i*NH + hist_m] >= 2;
    return (cho_m[i] >= 2) ? g : l;
  endfunction

  function automatic int sat(int v);
    return v < 0 ? 0 : (v > 3 ? 3 : v);
  endfunction

  task automatic m_reset(bit pg);
    for (int i = 0; i < NL; i++) begin loc_m[i] = 1; cho_m[i] = pg ? 3 : 0; end
    for (int i = 0; i < NL*NH; i++) glb_m[i] = 1;
    hist_m = 0;
  endtask

  task automatic m_update(int pc, bit t);
    int i = pc % NL;
    int gi = i*NH + hist_m;
    bit l = loc_m[i] >= 2;
    bit g = glb_m[gi] >= 2;
    if (l != g) cho_m[i] = sat(cho_m[i] + ((g == t) ? 1 : -1));
    loc_m[i] = sat(loc_m[i] + (t ? 1 : -1));
    glb_m[gi] = sat(glb_m[gi] + (t ? 1 : -1));
    hist_m = ((hist_m << 1) | t) % NH;
  endtask

  // inputs change at negedge; prediction compared before the edge, model advanced after
  task automatic step(int lpc, bit uv, int upc, bit ut, string tag);
    bit exp;
    lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut;
    #1;
    exp = m_pred(lpc);
    checks++;
    if (lk_taken !== exp) begin
      errors++;
      $display("FAIL %s pc=%0d actual=%b expected=%b", tag, lpc, lk_taken, exp);
    end
    @(posedge clk);
    if (uv) m_update(upc, ut);
    @(negedge clk);
  endtask

  task automatic do_reset(bit pg);
    @(negedge clk);
    rst_ni = 0; cfg = pg; up_valid = 0;
    #25;
    m_reset(pg);
    @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset(0);
    // R1: cleared state predicts not taken everywhere
    for (int p = 0; p < NL; p++) step(p, 0, 0, 0, "R1");
    // R2: saturating up, then hysteresis on the way down
    for (int k = 0; k < 5; k++) step(3, 1, 3, 1, "R2");
    for (int k = 0; k < 3; k++) step(3, 1, 3, 0, "R2");
    // R3: address aliasing on the low bits
    step(3 + NL, 1, 3 + NL, 1, "R3");
    step(3 + 2*NL, 0, 0, 0, "R3");
    // R4 R6: alternating branch learned by history, chooser flips after two wins
    for (int k = 0; k < 24; k++) step(7, 1, 7, k % 2, "R6");
    // R7: trained while unselected
    for (int k = 0; k < 6; k++) step(9, 1, 9, 1, "R7");
    // R8: lookup and resolve on the same entry in one cycle
    for (int k = 0; k < 6; k++) step(11, 1, 11, 1, "R8");
    for (int k = 0; k < 6; k++) step(11, 1, 11 + NL, 0, "R8");
    // R9: no resolve, nothing moves
    for (int k = 0; k < 40; k++) step(k % (2*NL), 0, k, 1, "R9");
    // R4: mixed traffic, per-address bias with noise
    for (int k = 0; k < 3000; k++) begin
      int p = $urandom_range(0, 2*NL-1);
      int q = $urandom_range(0, 2*NL-1);
      bit t = (q % 3 == 0) ? (k % 2 == 1) : ($urandom_range(0, 9) < 8) ^ (q % 2 == 1);
      step(p, $urandom_range(0, 9) < 7, q, t, "R4");
    end
    // R5: preference for the history side from reset
    do_reset(1);
    for (int p = 0; p < NL; p++) step(p, 0, 0, 0, "R5");
    for (int k = 0; k < 24; k++) step(5, 1, 5, (k % 4) < 2, "R5");
    for (int k = 0; k < 2000; k++) begin
      int p = $urandom_range(0, NL-1);
      int q = $urandom_range(0, NL-1);
      step(p, $urandom_range(0, 3) != 0, q, (k % 3) != 0, "R5");
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule